// File: doc/BRIEF.md
# Flash Write-Status Polling Generator

This block produces the bit-7 polling value and the ready/busy line that a flash device shows the host while an embedded program or erase runs. Commands arrive as a one-cycle `cmd_valid` pulse, issued once the last write pulse of a command sequence has ended. The array engine signals the end of an algorithm with `alg_done`. On every cycle the block decides whether a read at `rd_addr` should return status or the array's own bit 7, which the array side supplies on `array_d7`.

The status depends on both the kind of operation and the read address. A program shows the inverted target bit, but only at the target address. An erase shows 0 across every sector selected for erase, and 1 while the erase is suspended. A program or erase that targets only protected storage leaves the array unchanged. It still gives a short false-busy window whose length in clock cycles is a parameter, and then the block returns to array reads. A sector is the top `SECT_W` bits of an address.

Top module: `flash_wstat`

## Requirements
- R1: After reset, and whenever no status applies at the read address, `ry_by` is 1 (when idle), `stat_valid` is 0 and `dq7` equals `array_d7`.
- R2: A program command (`cmd_op`=00) accepted when idle to an unprotected sector makes `dq7` the inverse of `cmd_d7` at the target address only. `ry_by` stays 0 until `alg_done`, and then reads at that address return `array_d7`.
- R3: An erase command (`cmd_op`=01) with `cmd_sel` bit n marking sector n gives `dq7`=0 with `stat_valid`=1 at every selected sector while busy. Other sectors return array data, and `alg_done` ends the erase.
- R4: Suspend (`cmd_op`=10) during an erase gives `ry_by`=1 and `dq7`=1 at the selected sectors. Resume (`cmd_op`=11) brings back `ry_by`=0 and `dq7`=0.
- R5: While suspended, a program to a sector that is not selected for erase polls like R2 and returns to the suspended state on `alg_done`. A program to a sector that is selected for erase is ignored.
- R6: A program whose target sector has its `sect_prot` bit set holds `ry_by` at 0 for exactly `PGM_GUARD_CYC` cycles, showing the inverted bit at the target. `alg_done` is ignored. The block then returns to the state it came from, idle or suspended.
- R7: An erase whose selected sectors are all protected holds `ry_by` at 0 for exactly `ERS_GUARD_CYC` cycles, with `dq7`=0 at the selected sectors, and then returns to idle.
- R8: An erase that selects both protected and unprotected sectors runs as a normal erase. It ends on `alg_done`, and status shows at every selected sector.
- R9: Commands are ignored when they do not apply: program or erase while busy, suspend outside an erase, resume outside suspend, and an erase with an empty selection.
- R10: A command sampled with `cmd_valid` at a clock edge sets the outputs from the cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | One-cycle pulse: a command sequence has completed |
| cmd_op | input | 2 | 00 program, 01 erase, 10 suspend, 11 resume |
| cmd_addr | input | ADDR_W | Program target address |
| cmd_d7 | input | 1 | Bit 7 of the datum being programmed |
| cmd_sel | input | 2**SECT_W | Sectors selected for erase |
| sect_prot | input | 2**SECT_W | Per-sector protection flags |
| alg_done | input | 1 | Embedded algorithm finished |
| rd_addr | input | ADDR_W | Current read address |
| array_d7 | input | 1 | Array bit 7 at `rd_addr` |
| dq7 | output | 1 | Bit 7 returned to the host |
| stat_valid | output | 1 | 1 when `dq7` carries status instead of array data |
| ry_by | output | 1 | 1 ready, 0 busy |

## Verification
The bench builds the block with an 8-bit address and four sectors. This makes every sector selection pattern, and both protected and unprotected targets, easy to reach with short literal addresses. The guard windows are set to 5 and 23 cycles. The bench counts every busy cycle of both windows, so an error of one cycle at either end is detected. Holding `alg_done` high through a window shows that the timer alone ends it.

// File: rtl/flash_wstat_pkg.sv
package flash_wstat_pkg;

  typedef enum logic [1:0] {
    OP_PGM  = 2'b00,
    OP_ERS  = 2'b01,
    OP_SUSP = 2'b10,
    OP_RES  = 2'b11
  } op_e;

  typedef enum logic [2:0] {
    M_IDLE   = 3'd0,
    M_PGM    = 3'd1,
    M_ERS    = 3'd2,
    M_SUSP   = 3'd3,
    M_SPGM   = 3'd4,
    M_PGUARD = 3'd5,
    M_EGUARD = 3'd6
  } mode_e;

  // busy means the ready/busy line is driven low
  function automatic logic mode_busy(mode_e m);
    return (m == M_PGM) || (m == M_ERS) || (m == M_SPGM) ||
           (m == M_PGUARD) || (m == M_EGUARD);
  endfunction

  // polling value for a program: inverse of the bit being written
  function automatic logic poll_pgm(logic target_bit);
    return ~target_bit;
  endfunction

  // polling value for an erase: 0 while erasing, 1 when suspended
  function automatic logic poll_ers(logic suspended);
    return suspended;
  endfunction

  // an erase runs only if some selected sector is writable
  function automatic logic all_locked(logic [63:0] sel, logic [63:0] prot);
    return (sel & ~prot) == 64'd0;
  endfunction

endpackage

// File: rtl/fsst_sect_dec.sv
module fsst_sect_dec #(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 4,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [NSECT-1:0]  mask,
  output logic [NSECT-1:0]  hot,
  output logic              hit
);
  localparam int LSB = ADDR_W - SECT_W;

  logic [SECT_W-1:0] idx;
  assign idx = addr[ADDR_W-1:LSB];

  for (genvar g = 0; g < NSECT; g++) begin : g_hot
    assign hot[g] = (idx == SECT_W'(g));
  end

  assign hit = |(hot & mask);
endmodule

// File: rtl/fsst_guard_timer.sv
module fsst_guard_timer #(
  parameter int PGM_CYC = 100,
  parameter int ERS_CYC = 10000,
  localparam int MAXC  = (PGM_CYC > ERS_CYC) ? PGM_CYC : ERS_CYC,
  localparam int CNT_W = $clog2(MAXC + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic long_win,
  output logic expire
);
  localparam logic [CNT_W-1:0] PGM_INIT = CNT_W'(PGM_CYC - 1);
  localparam logic [CNT_W-1:0] ERS_INIT = CNT_W'(ERS_CYC - 1);

  logic [CNT_W-1:0] cnt;
  logic             run;

  assign expire = run && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (load) begin
      cnt <= long_win ? ERS_INIT : PGM_INIT;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == '0) run <= 1'b0;
      else           cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/fsst_seq.sv
module fsst_seq
  import flash_wstat_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int SECT_W = 4,
  localparam int NSECT = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_d7,
  input  logic [NSECT-1:0]  cmd_sel,
  input  logic [NSECT-1:0]  sect_prot,
  input  logic              tgt_locked,
  input  logic              tgt_in_ers,
  input  logic              alg_done,
  input  logic              guard_done,
  output mode_e             mode,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              tgt_d7,
  output logic [NSECT-1:0]  ers_sel,
  output logic              ret_susp,
  output logic              load_guard,
  output logic              load_long
);
  mode_e mode_nx;
  logic  take_pgm_idle, take_pgm_susp, take_ers, take_susp, take_res;
  logic  ers_locked;

  assign ers_locked    = all_locked(64'(cmd_sel), 64'(sect_prot));
  assign take_pgm_idle = cmd_valid && (cmd_op == OP_PGM) && (mode == M_IDLE);
  assign take_pgm_susp = cmd_valid && (cmd_op == OP_PGM) && (mode == M_SUSP) && !tgt_in_ers;
  assign take_ers      = cmd_valid && (cmd_op == OP_ERS) && (mode == M_IDLE) && (|cmd_sel);
  assign take_susp     = cmd_valid && (cmd_op == OP_SUSP) && (mode == M_ERS) && !alg_done;
  assign take_res      = cmd_valid && (cmd_op == OP_RES) && (mode == M_SUSP);

  always_comb begin
    mode_nx    = mode;
    load_guard = 1'b0;
    load_long  = 1'b0;
    unique case (mode)
      M_IDLE: begin
        if (take_pgm_idle) begin
          mode_nx    = tgt_locked ? M_PGUARD : M_PGM;
          load_guard = tgt_locked;
        end else if (take_ers) begin
          mode_nx    = ers_locked ? M_EGUARD : M_ERS;
          load_guard = ers_locked;
          load_long  = ers_locked;
        end
      end
      M_PGM:  if (alg_done) mode_nx = M_IDLE;
      M_ERS: begin
        if (alg_done)       mode_nx = M_IDLE;
        else if (take_susp) mode_nx = M_SUSP;
      end
      M_SUSP: begin
        if (take_pgm_susp) begin
          mode_nx    = tgt_locked ? M_PGUARD : M_SPGM;
          load_guard = tgt_locked;
        end else if (take_res) begin
          mode_nx = M_ERS;
        end
      end
      M_SPGM:   if (alg_done) mode_nx = M_SUSP;
      M_PGUARD: if (guard_done) mode_nx = ret_susp ? M_SUSP : M_IDLE;
      M_EGUARD: if (guard_done) mode_nx = M_IDLE;
      default:  mode_nx = M_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode     <= M_IDLE;
      tgt_addr <= '0;
      tgt_d7   <= 1'b0;
      ers_sel  <= '0;
      ret_susp <= 1'b0;
    end else begin
      mode <= mode_nx;
      if (take_pgm_idle || take_pgm_susp) begin
        tgt_addr <= cmd_addr;
        tgt_d7   <= cmd_d7;
        ret_susp <= take_pgm_susp;
      end
      if (take_ers) ers_sel <= cmd_sel;
    end
  end
endmodule

// File: rtl/fsst_status.sv
module fsst_status
  import flash_wstat_pkg::*;
(
  input  mode_e mode,
  input  logic  rd_at_tgt,
  input  logic  rd_in_sel,
  input  logic  tgt_d7,
  input  logic  ret_susp,
  input  logic  array_d7,
  output logic  dq7,
  output logic  stat_valid
);
  logic poll;

  always_comb begin
    stat_valid = 1'b0;
    poll       = 1'b0;
    unique case (mode)
      M_PGM: begin
        stat_valid = rd_at_tgt;
        poll       = poll_pgm(tgt_d7);
      end
      M_ERS, M_EGUARD: begin
        stat_valid = rd_in_sel;
        poll       = poll_ers(1'b0);
      end
      M_SUSP: begin
        stat_valid = rd_in_sel;
        poll       = poll_ers(1'b1);
      end
      M_SPGM: begin
        stat_valid = rd_at_tgt || rd_in_sel;
        poll       = rd_at_tgt ? poll_pgm(tgt_d7) : poll_ers(1'b1);
      end
      M_PGUARD: begin
        stat_valid = rd_at_tgt || (ret_susp && rd_in_sel);
        poll       = rd_at_tgt ? poll_pgm(tgt_d7) : poll_ers(1'b1);
      end
      default: begin
        stat_valid = 1'b0;
        poll       = 1'b0;
      end
    endcase
    dq7 = stat_valid ? poll : array_d7;
  end
endmodule

// File: rtl/flash_wstat.sv
module flash_wstat
  import flash_wstat_pkg::*;
#(
  parameter int ADDR_W        = 16,
  parameter int SECT_W        = 4,
  parameter int PGM_GUARD_CYC = 100,
  parameter int ERS_GUARD_CYC = 10000,
  localparam int NSECT        = 1 << SECT_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_d7,
  input  logic [NSECT-1:0]  cmd_sel,
  input  logic [NSECT-1:0]  sect_prot,
  input  logic              alg_done,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic              array_d7,
  output logic              dq7,
  output logic              stat_valid,
  output logic              ry_by
);
  mode_e             mode;
  logic [ADDR_W-1:0] tgt_addr;
  logic              tgt_d7;
  logic [NSECT-1:0]  ers_sel;
  logic              ret_susp;
  logic              load_guard, load_long, guard_done;
  logic [NSECT-1:0]  cmd_hot, rd_hot;
  logic              tgt_locked, tgt_in_ers, rd_in_sel, rd_at_tgt;

  // named internal events for the checker
  logic guard_act, guard_ers, ers_busy, susp_act;
  assign guard_act = (mode == M_PGUARD) || (mode == M_EGUARD);
  assign guard_ers = (mode == M_EGUARD);
  assign ers_busy  = (mode == M_ERS) || (mode == M_EGUARD);
  assign susp_act  = (mode == M_SUSP);

  fsst_sect_dec #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_cmd_dec (
    .addr(cmd_addr), .mask(sect_prot), .hot(cmd_hot), .hit(tgt_locked)
  );

  fsst_sect_dec #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_rd_dec (
    .addr(rd_addr), .mask(ers_sel), .hot(rd_hot), .hit(rd_in_sel)
  );

  assign tgt_in_ers = |(cmd_hot & ers_sel);
  assign rd_at_tgt  = (rd_addr == tgt_addr);

  fsst_seq #(.ADDR_W(ADDR_W), .SECT_W(SECT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_d7(cmd_d7), .cmd_sel(cmd_sel),
    .sect_prot(sect_prot), .tgt_locked(tgt_locked), .tgt_in_ers(tgt_in_ers),
    .alg_done(alg_done), .guard_done(guard_done), .mode(mode),
    .tgt_addr(tgt_addr), .tgt_d7(tgt_d7), .ers_sel(ers_sel),
    .ret_susp(ret_susp), .load_guard(load_guard), .load_long(load_long)
  );

  fsst_guard_timer #(.PGM_CYC(PGM_GUARD_CYC), .ERS_CYC(ERS_GUARD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(load_guard), .long_win(load_long),
    .expire(guard_done)
  );

  fsst_status u_stat (
    .mode(mode), .rd_at_tgt(rd_at_tgt), .rd_in_sel(rd_in_sel),
    .tgt_d7(tgt_d7), .ret_susp(ret_susp), .array_d7(array_d7),
    .dq7(dq7), .stat_valid(stat_valid)
  );

  assign ry_by = ~mode_busy(mode);
endmodule

// File: rtl/flash_wstat_chk.sv
module flash_wstat_chk #(
  parameter int PGM_CYC = 100,
  parameter int ERS_CYC = 10000
) (
  input logic clk,
  input logic rst_n,
  input logic cmd_valid,
  input logic alg_done,
  input logic ry_by,
  input logic stat_valid,
  input logic dq7,
  input logic array_d7,
  input logic guard_act,
  input logic guard_ers,
  input logic ers_busy,
  input logic rd_in_sel,
  input logic susp_act
);
  int unsigned run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         run_len <= 0;
    else if (guard_act) run_len <= run_len + 1;
    else                run_len <= 0;
  end

  AST_ARRAY_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_valid |-> (dq7 == array_d7)); // R1
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ry_by && !guard_act && !alg_done && !cmd_valid) |=> !ry_by); // R2
  AST_ERS_POLL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (ers_busy && rd_in_sel) |-> (stat_valid && !dq7)); // R3
  AST_SUSP_READY: assert property (@(posedge clk) disable iff (!rst_n)
    susp_act |-> ry_by); // R4
  AST_PGM_GUARD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_act && !guard_ers) |-> (run_len < PGM_CYC)); // R6
  AST_ERS_GUARD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_act && guard_ers) |-> (run_len < ERS_CYC)); // R7
endmodule

bind flash_wstat flash_wstat_chk #(
  .PGM_CYC(PGM_GUARD_CYC), .ERS_CYC(ERS_GUARD_CYC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .alg_done(alg_done),
  .ry_by(ry_by), .stat_valid(stat_valid), .dq7(dq7), .array_d7(array_d7),
  .guard_act(guard_act), .guard_ers(guard_ers), .ers_busy(ers_busy),
  .rd_in_sel(rd_in_sel), .susp_act(susp_act)
);

// File: tb/flash_wstat_bench.sv
module flash_wstat_bench;
  localparam int AW = 8;
  localparam int SW = 2;
  localparam int PG = 5;
  localparam int EG = 23;

  localparam logic [1:0] C_PGM = 2'b00, C_ERS = 2'b01, C_SUS = 2'b10, C_RES = 2'b11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [1:0] cmd_op = 2'b00;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_d7 = 1'b0;
  logic [3:0] cmd_sel = '0;
  logic [3:0] sect_prot = 4'b1000;
  logic alg_done = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic array_d7 = 1'b0;
  logic dq7, stat_valid, ry_by;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #5 clk = ~clk;

  flash_wstat #(.ADDR_W(AW), .SECT_W(SW), .PGM_GUARD_CYC(PG), .ERS_GUARD_CYC(EG)) u_flash_wstat (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .cmd_d7(cmd_d7), .cmd_sel(cmd_sel),
    .sect_prot(sect_prot), .alg_done(alg_done), .rd_addr(rd_addr),
    .array_d7(array_d7), .dq7(dq7), .stat_valid(stat_valid), .ry_by(ry_by)
  );

  typedef struct packed {
    logic       cv;
    logic [1:0] op;
    logic [7:0] addr;
    logic       d7;
    logic [3:0] sel;
    logic       done;
    logic [7:0] ra;
    logic       ad7;
    logic       e_dq7;
    logic       e_sv;
    logic       e_ry;
    logic [3:0] rq;
  } vec_t;

  // cv op addr d7 sel done ra ad7 | dq7 sv ry | req ; sector = addr[7:6], sector 3 protected
  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h10, 1'b0, 1'b0, 1'b0, 1'b1, 4'd1},  // R1
    '{1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h10, 1'b1, 1'b1, 1'b0, 1'b1, 4'd1},  // R1
    '{1'b1, C_PGM, 8'h12, 1'b1, 4'b0000, 1'b0, 8'h12, 1'b1, 1'b0, 1'b1, 1'b0, 4'd10}, // R10 R2
    '{1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h13, 1'b1, 1'b1, 1'b0, 1'b0, 4'd2},  // R2
    '{1'b1, C_PGM, 8'h20, 1'b0, 4'b0000, 1'b0, 8'h12, 1'b1, 1'b0, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b1, 8'h12, 1'b1, 1'b1, 1'b0, 1'b1, 4'd2},  // R2
    '{1'b1, C_ERS, 8'h00, 1'b0, 4'b0011, 1'b0, 8'h45, 1'b1, 1'b0, 1'b1, 1'b0, 4'd3},  // R3
    '{1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h85, 1'b1, 1'b1, 1'b0, 1'b0, 4'd3},  // R3
    '{1'b1, C_SUS, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h05, 1'b0, 1'b1, 1'b1, 1'b1, 4'd4},  // R4
    '{1'b1, C_PGM, 8'h90, 1'b0, 4'b0000, 1'b0, 8'h90, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
    '{1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h05, 1'b0, 1'b1, 1'b1, 1'b0, 4'd5},  // R5
    '{1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b1, 8'h90, 1'b0, 1'b0, 1'b0, 1'b1, 4'd5},  // R5
    '{1'b1, C_PGM, 8'h30, 1'b0, 4'b0000, 1'b0, 8'h30, 1'b0, 1'b1, 1'b1, 1'b1, 4'd5},  // R5
    '{1'b1, C_RES, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h30, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},  // R4
    '{1'b1, C_RES, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h30, 1'b1, 1'b0, 1'b1, 1'b0, 4'd9},  // R9
    '{1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b1, 8'h30, 1'b0, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{1'b1, C_SUS, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h30, 1'b0, 1'b0, 1'b0, 1'b1, 4'd9},  // R9
    '{1'b1, C_ERS, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h30, 1'b1, 1'b1, 1'b0, 1'b1, 4'd9},  // R9
    '{1'b1, C_ERS, 8'h00, 1'b0, 4'b1001, 1'b0, 8'hC4, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h04, 1'b1, 1'b0, 1'b1, 1'b0, 4'd8},  // R8
    '{1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b1, 8'hC4, 1'b1, 1'b1, 1'b0, 1'b1, 4'd8}   // R8
  };

  task automatic check(input int rq, input logic e_dq7, input logic e_sv, input logic e_ry);
    n_chk++;
    if (dq7 !== e_dq7 || stat_valid !== e_sv || ry_by !== e_ry) begin
      n_bad++;
      $display("FAIL R%0d: dq7/sv/ry = %b%b%b, expected %b%b%b",
               rq, dq7, stat_valid, ry_by, e_dq7, e_sv, e_ry);
    end
  endtask

  task automatic count_check(input int rq, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL R%0d: busy window %0d cycles, expected %0d", rq, got, exp);
    end
  endtask

  task automatic step(input logic cv, input logic [1:0] op, input logic [7:0] ad,
                      input logic d7, input logic [3:0] sel, input logic dn,
                      input logic [7:0] ra, input logic ad7);
    @(negedge clk);
    cmd_valid = cv; cmd_op = op; cmd_addr = ad; cmd_d7 = d7; cmd_sel = sel;
    alg_done = dn; rd_addr = ra; array_d7 = ad7;
    @(posedge clk);
    #2;
  endtask

  // issue a command that opens a guard window; count busy cycles, alg_done held high
  task automatic guard_window(input int rq, input logic [1:0] op, input logic [7:0] ad,
                              input logic d7, input logic [3:0] sel, input logic [7:0] ra,
                              input logic e_dq7, output int len);
    int bad_poll = 0;
    len = 0;
    step(1'b1, op, ad, d7, sel, 1'b1, ra, ~e_dq7);
    while (!ry_by && len < 200) begin
      len++;
      if (dq7 !== e_dq7 || !stat_valid) bad_poll++;
      step(1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b1, ra, ~e_dq7);
    end
    n_chk++;
    if (bad_poll != 0) begin
      n_bad++;
      $display("FAIL R%0d: %0d window cycles with wrong polling, expected 0", rq, bad_poll);
    end
  endtask

  task automatic summary();
    if (!done_flag) begin
      done_flag = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
  end

  initial begin
    int len;
    rd_addr = 8'h10; array_d7 = 1'b1;
    repeat (3) @(posedge clk);
    #2;
    check(1, 1'b1, 1'b0, 1'b1); // R1 during reset
    @(negedge clk) rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i].cv, VEC[i].op, VEC[i].addr, VEC[i].d7, VEC[i].sel,
           VEC[i].done, VEC[i].ra, VEC[i].ad7);
      check(int'(VEC[i].rq), VEC[i].e_dq7, VEC[i].e_sv, VEC[i].e_ry);
    end

    // R6: protected program from idle
    guard_window(6, C_PGM, 8'hC8, 1'b1, 4'b0000, 8'hC8, 1'b0, len);
    count_check(6, len, PG);
    step(1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b0, 8'hC8, 1'b1);
    check(6, 1'b1, 1'b0, 1'b1); // R6 array unchanged path

    // R7: erase of only protected sectors
    guard_window(7, C_ERS, 8'h00, 1'b0, 4'b1000, 8'hC0, 1'b0, len);
    count_check(7, len, EG);
    step(1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b0, 8'hC0, 1'b1);
    check(7, 1'b1, 1'b0, 1'b1);

    // R6 inside erase suspend: returns to suspended state
    step(1'b1, C_ERS, 8'h00, 1'b0, 4'b0001, 1'b0, 8'h05, 1'b1);
    step(1'b1, C_SUS, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h05, 1'b0);
    guard_window(6, C_PGM, 8'hD0, 1'b0, 4'b0000, 8'hD0, 1'b1, len);
    count_check(6, len, PG);
    step(1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h05, 1'b0);
    check(6, 1'b1, 1'b1, 1'b1); // R6 back in suspend (R4 polling 1)
    step(1'b1, C_RES, 8'h00, 1'b0, 4'b0000, 1'b0, 8'h05, 1'b1);
    check(4, 1'b0, 1'b1, 1'b0); // R4 resume
    step(1'b0, C_PGM, 8'h00, 1'b0, 4'b0000, 1'b1, 8'h05, 1'b1);
    check(3, 1'b1, 1'b0, 1'b1); // R3 erase done

    // R1: reset in the middle of an erase
    step(1'b1, C_ERS, 8'h00, 1'b0, 4'b0010, 1'b0, 8'h44, 1'b1);
    check(3, 1'b0, 1'b1, 1'b0);
    @(negedge clk) rst_n = 1'b0;
    #2;
    check(1, 1'b1, 1'b0, 1'b1);
    @(negedge clk) rst_n = 1'b1;

    summary();
  end
endmodule